// File: doc/BRIEF.md
# Discharge Short-Circuit Protection Controller

This block guards a battery pack against short circuits while it discharges. Every clock cycle it compares a signed current sample, where discharge is negative, with two trip levels. Each level has its own threshold code and qualification delay. A qualified trip sets a fault flag and asserts a discharge-disable output. The fault clears itself once a programmable recovery time has passed.

Each trip event also increments a saturating fault counter. The counter leaks back towards zero while the current sits above both limits. A non-zero count raises an alert flag. A second alert flag follows it, but only when permanent-failure reporting is enabled.

When the count reaches a programmable limit, the block enters a latched fault. That latch then clears in one of two ways, selected by a configuration bit:
- a timed release, or
- a low-high-low sequence on the pack-presence pin.

All timers advance on a single-cycle time-base tick. The block has no host register access and no analog sense path. Everything arrives as plain configuration inputs.

Top module: `scd_guard`

## Requirements
- R1: Each level's configuration byte holds a threshold code in bits [2:0] and a delay code in bits [7:4]; bit 3 is ignored. The level's limit is -(THR_BASE + code*THR_STEP), which is -(100 + 50*code) by default. A level counts as exceeded when curSample is less than or equal to its limit. Either level alone can cause a trip.
- R2: A level qualifies after it has stayed exceeded for at least the number of ticks in its delay code. With a delay code of 0 it qualifies in the first cycle it is exceeded. A qualified trip sets faultFlag and dsgOff on the next clock edge.
- R3: Once faultFlag has been set for max(recTime,1) ticks, it clears. dsgOff clears with it unless latchFlag is set.
- R4: The fault counter increments once per trip event, meaning when a level qualifies while faultFlag and latchFlag are both clear. Holding the current below the limit does not add further counts. The counter saturates at 2^CNT_W-1, which is 15 by default.
- R5: The counter decrements by one after each max(decPeriod,1) ticks while both levels are not exceeded and the count is non-zero. The decrement timer reloads whenever that condition is false.
- R6: alertFlag is 1 exactly when the count is non-zero. pfAlert equals alertFlag AND pfEnable.
- R7: When latchLimit is non-zero and the count is greater than or equal to latchLimit, the next clock edge does all of the following:
  - sets latchFlag and keeps dsgOff at 1;
  - clears faultFlag and zeroes the count, so alertFlag and pfAlert drop;
  - sets pfStatus if pfEnable is 1.

  While latchFlag is set, trips are ignored.
- R8: With resetMode=0, latchFlag clears only after the synchronized presPin has been seen low, then high, then low, all while latched.
- R9: With resetMode=1, latchFlag clears after it has been set for max(rstTime,1) ticks.
- R10: pfStatus is sticky and only the synchronous active-low reset clears it. Reset clears all flags, the counter and all timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle time-base strobe |
| curSample | input | CUR_W (16) | Signed current sample, negative in discharge |
| lvlCfg | input | 2x8 | Per-level configuration: threshold code [2:0], delay code [7:4] |
| recTime | input | TIME_W (8) | Fault recovery time in ticks |
| rstTime | input | TIME_W (8) | Timed latch release in ticks |
| decPeriod | input | TIME_W (8) | Counter decrement period in ticks |
| latchLimit | input | CNT_W (4) | Count that escalates to the latch; 0 disables it |
| pfEnable | input | 1 | Permanent-failure reporting enable |
| resetMode | input | 1 | Latch release: 0 presence sequence, 1 timed |
| presPin | input | 1 | Asynchronous pack-presence pin |
| dsgOff | output | 1 | Discharge disable |
| faultFlag | output | 1 | Short-circuit fault active |
| latchFlag | output | 1 | Latched fault active |
| alertFlag | output | 1 | Fault counter non-zero |
| pfAlert | output | 1 | Permanent-failure alert |
| pfStatus | output | 1 | Sticky permanent-failure status |

## Verification
The assertions check the relations that must hold on every cycle:
- a latched fault never coexists with an active fault;
- a latched fault arrives with both alerts cleared;
- permanent-failure status never drops and only rises when enabled;
- fault recovery and timed latch release only happen on a tick.

The exact threshold boundaries, qualification delays, recovery and decrement durations, counter saturation and both latch-release sequences depend on tick counts and configuration. Only the bench's sweeps can show these, by comparing arithmetic expectations with the flags.

// File: rtl/scd_guard_pkg.sv
package scd_guard_pkg;
  localparam int NUM_LVL    = 2;
  localparam int CFG_W      = 8;
  localparam int THR_CODE_W = 3;
  localparam int DLY_CODE_W = 4;

  // control -> datapath
  typedef struct packed {
    logic cntInc;
    logic cntClear;
    logic recRun;
    logic rstRun;
  } scdStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic tripNow;
    logic cntNonZero;
    logic latchHit;
    logic recDone;
    logic rstDone;
  } scdEvent_t;

  typedef enum logic [1:0] {
    PRES_WAIT_LOW  = 2'd0,
    PRES_SEEN_LOW  = 2'd1,
    PRES_SEEN_HIGH = 2'd2
  } presState_t;
endpackage

// File: rtl/scd_level.sv
module scd_level #(
  parameter int CUR_W    = 16,
  parameter int THR_BASE = 100,
  parameter int THR_STEP = 50
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic signed [CUR_W-1:0] curSample,
  input  logic [2:0]              thrCode,
  input  logic [3:0]              dlyCode,
  output logic                    below,
  output logic                    hit
);
  int                     limitInt;
  logic signed [CUR_W-1:0] limit;
  logic [3:0]             qCnt;

  always_comb begin
    limitInt = -(THR_BASE + int'(thrCode) * THR_STEP);
    limit    = limitInt[CUR_W-1:0];
    below    = (curSample <= limit);
    hit      = below && (qCnt >= dlyCode);
  end

  // qualification timer: restarts as soon as the level is no longer exceeded
  always_ff @(posedge clk) begin
    if (!rstN || !below) qCnt <= '0;
    else if (tick && (qCnt < dlyCode)) qCnt <= qCnt + 4'd1;
  end
endmodule

// File: rtl/scd_timer.sv
module scd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic         done
);
  logic [W-1:0] tmr;
  logic [W:0]   nextCnt;

  always_comb begin
    nextCnt = {1'b0, tmr} + (W+1)'(1);
    done    = run && tick && (nextCnt >= {1'b0, period});
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run) tmr <= '0;
    else if (tick)     tmr <= done ? '0 : tmr + W'(1);
  end
endmodule

// File: rtl/scd_datapath.sv
module scd_datapath
  import scd_guard_pkg::*;
#(
  parameter int CUR_W    = 16,
  parameter int TIME_W   = 8,
  parameter int CNT_W    = 4,
  parameter int THR_BASE = 100,
  parameter int THR_STEP = 50
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              tick,
  input  logic signed [CUR_W-1:0]           curSample,
  input  logic [NUM_LVL-1:0][CFG_W-1:0]     lvlCfg,
  input  logic [TIME_W-1:0]                 recTime,
  input  logic [TIME_W-1:0]                 rstTime,
  input  logic [TIME_W-1:0]                 decPeriod,
  input  logic [CNT_W-1:0]                  latchLimit,
  input  scdStrobe_t                        strobe,
  output scdEvent_t                         evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_LVL-1:0] belowVec;
  logic [NUM_LVL-1:0] hitVec;
  logic [NUM_LVL-1:0] unusedCfgBits;
  logic [CNT_W-1:0]   cnt;
  logic               aboveAll;
  logic               decRun;
  logic               decFire;

  for (genvar g = 0; g < NUM_LVL; g++) begin : gLvl
    scd_level #(
      .CUR_W(CUR_W), .THR_BASE(THR_BASE), .THR_STEP(THR_STEP)
    ) uLevel (
      .clk(clk), .rstN(rstN), .tick(tick), .curSample(curSample),
      .thrCode(lvlCfg[g][2:0]), .dlyCode(lvlCfg[g][7:4]),
      .below(belowVec[g]), .hit(hitVec[g])
    );
    assign unusedCfgBits[g] = lvlCfg[g][3];
  end

  assign aboveAll = ~|belowVec;
  assign decRun   = aboveAll && (cnt != '0) && !strobe.cntInc && !strobe.cntClear;

  scd_timer #(.W(TIME_W)) uDecTmr (
    .clk(clk), .rstN(rstN), .run(decRun), .tick(tick),
    .period(decPeriod), .done(decFire)
  );
  scd_timer #(.W(TIME_W)) uRecTmr (
    .clk(clk), .rstN(rstN), .run(strobe.recRun), .tick(tick),
    .period(recTime), .done(evt.recDone)
  );
  scd_timer #(.W(TIME_W)) uRstTmr (
    .clk(clk), .rstN(rstN), .run(strobe.rstRun), .tick(tick),
    .period(rstTime), .done(evt.rstDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClear)               cnt <= '0;
    else if (strobe.cntInc && (cnt != CNT_MAX)) cnt <= cnt + CNT_W'(1);
    else if (decFire)                           cnt <= cnt - CNT_W'(1);
  end

  assign evt.tripNow    = |hitVec;
  assign evt.cntNonZero = (cnt != '0);
  assign evt.latchHit   = (latchLimit != '0) && (cnt >= latchLimit);
endmodule

// File: rtl/scd_control.sv
module scd_control
  import scd_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  scdEvent_t  evt,
  input  logic       pfEnable,
  input  logic       resetMode,
  input  logic       presPin,
  output scdStrobe_t strobe,
  output logic       dsgOff,
  output logic       faultFlag,
  output logic       latchFlag,
  output logic       alertFlag,
  output logic       pfAlert,
  output logic       pfStatus
);
  logic       faultQ, latchQ, pfQ;
  logic       presS1, presS2;
  presState_t presState;
  logic       tripEvent, latchSet, presPulse, latchRelease, presArm;

  always_comb begin
    tripEvent    = evt.tripNow && !faultQ && !latchQ;
    latchSet     = evt.latchHit && !latchQ;
    presArm      = latchQ && !resetMode;
    presPulse    = presArm && (presState == PRES_SEEN_HIGH) && !presS2;
    latchRelease = latchQ && (resetMode ? evt.rstDone : presPulse);

    strobe.cntInc   = tripEvent;
    strobe.cntClear = latchSet;
    strobe.recRun   = faultQ;
    strobe.rstRun   = latchQ && resetMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presS1 <= 1'b0;
      presS2 <= 1'b0;
    end else begin
      presS1 <= presPin;
      presS2 <= presS1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !presArm) presState <= PRES_WAIT_LOW;
    else begin
      unique case (presState)
        PRES_WAIT_LOW:  if (!presS2) presState <= PRES_SEEN_LOW;
        PRES_SEEN_LOW:  if (presS2)  presState <= PRES_SEEN_HIGH;
        PRES_SEEN_HIGH: if (!presS2) presState <= PRES_SEEN_LOW;
        default:                     presState <= PRES_WAIT_LOW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ <= 1'b0;
      latchQ <= 1'b0;
      pfQ    <= 1'b0;
    end else begin
      if (latchSet)         faultQ <= 1'b0;
      else if (tripEvent)   faultQ <= 1'b1;
      else if (evt.recDone) faultQ <= 1'b0;

      if (latchSet)          latchQ <= 1'b1;
      else if (latchRelease) latchQ <= 1'b0;

      if (latchSet && pfEnable) pfQ <= 1'b1;
    end
  end

  assign faultFlag = faultQ;
  assign latchFlag = latchQ;
  assign dsgOff    = faultQ | latchQ;
  assign alertFlag = evt.cntNonZero;
  assign pfAlert   = evt.cntNonZero && pfEnable;
  assign pfStatus  = pfQ;
endmodule

// File: rtl/scd_guard.sv
module scd_guard
  import scd_guard_pkg::*;
#(
  parameter int CUR_W    = 16,
  parameter int TIME_W   = 8,
  parameter int CNT_W    = 4,
  parameter int THR_BASE = 100,
  parameter int THR_STEP = 50
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  logic signed [CUR_W-1:0]       curSample,
  input  logic [NUM_LVL-1:0][CFG_W-1:0] lvlCfg,
  input  logic [TIME_W-1:0]             recTime,
  input  logic [TIME_W-1:0]             rstTime,
  input  logic [TIME_W-1:0]             decPeriod,
  input  logic [CNT_W-1:0]              latchLimit,
  input  logic                          pfEnable,
  input  logic                          resetMode,
  input  logic                          presPin,
  output logic                          dsgOff,
  output logic                          faultFlag,
  output logic                          latchFlag,
  output logic                          alertFlag,
  output logic                          pfAlert,
  output logic                          pfStatus
);
  scdStrobe_t strobe;
  scdEvent_t  evt;

  scd_datapath #(
    .CUR_W(CUR_W), .TIME_W(TIME_W), .CNT_W(CNT_W),
    .THR_BASE(THR_BASE), .THR_STEP(THR_STEP)
  ) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .curSample(curSample),
    .lvlCfg(lvlCfg), .recTime(recTime), .rstTime(rstTime),
    .decPeriod(decPeriod), .latchLimit(latchLimit),
    .strobe(strobe), .evt(evt)
  );

  scd_control uCtl (
    .clk(clk), .rstN(rstN), .evt(evt), .pfEnable(pfEnable),
    .resetMode(resetMode), .presPin(presPin), .strobe(strobe),
    .dsgOff(dsgOff), .faultFlag(faultFlag), .latchFlag(latchFlag),
    .alertFlag(alertFlag), .pfAlert(pfAlert), .pfStatus(pfStatus)
  );
endmodule

// File: rtl/scd_guard_chk.sv
module scd_guard_chk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic pfEnable,
  input logic resetMode,
  input logic dsgOff,
  input logic faultFlag,
  input logic latchFlag,
  input logic alertFlag,
  input logic pfAlert,
  input logic pfStatus
);
  AST_DSG_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultFlag) |-> dsgOff); // R2

  AST_RECOVER_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(faultFlag) && !latchFlag) |-> $past(tick)); // R3

  AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    latchFlag |-> !faultFlag); // R7

  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchFlag) |-> (!alertFlag && !pfAlert && dsgOff)); // R7

  AST_PF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfStatus) |-> $past(pfEnable)); // R7

  AST_TIMED_RELEASE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(latchFlag) && $past(resetMode)) |-> $past(tick)); // R9

  AST_PF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    pfStatus |=> pfStatus); // R10
endmodule

bind scd_guard scd_guard_chk uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .pfEnable(pfEnable),
  .resetMode(resetMode), .dsgOff(dsgOff), .faultFlag(faultFlag),
  .latchFlag(latchFlag), .alertFlag(alertFlag), .pfAlert(pfAlert),
  .pfStatus(pfStatus)
);

// File: tb/sim_scd_guard.sv
`timescale 1ns/1ps
module sim_scd_guard;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic signed [15:0] curSample = '0;
  logic [1:0][7:0]   lvlCfg = '0;
  logic [7:0]        recTime = 8'd255;
  logic [7:0]        rstTime = 8'd255;
  logic [7:0]        decPeriod = 8'd255;
  logic [3:0]        latchLimit = 4'd0;
  logic              pfEnable = 1'b0;
  logic              resetMode = 1'b0;
  logic              presPin = 1'b0;
  logic dsgOff, faultFlag, latchFlag, alertFlag, pfAlert, pfStatus;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scd_guard u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .curSample(curSample),
    .lvlCfg(lvlCfg), .recTime(recTime), .rstTime(rstTime),
    .decPeriod(decPeriod), .latchLimit(latchLimit), .pfEnable(pfEnable),
    .resetMode(resetMode), .presPin(presPin), .dsgOff(dsgOff),
    .faultFlag(faultFlag), .latchFlag(latchFlag), .alertFlag(alertFlag),
    .pfAlert(pfAlert), .pfStatus(pfStatus)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickOnce();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic doReset();
    curSample = '0;
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  function automatic logic signed [15:0] limitOf(input int code);
    return 16'(-(100 + 50 * code));
  endfunction

  // one trip on level 0 (delay 0, limit -100), then current released
  task automatic tripOnce();
    curSample = -16'sd100;
    cyc(1);
    curSample = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    doReset();
    // R10: reset state
    chk(dsgOff, 0, "R10 reset dsgOff");
    chk(faultFlag, 0, "R10 reset fault");
    chk(latchFlag, 0, "R10 reset latch");
    chk(alertFlag, 0, "R10 reset alert");
    chk(pfStatus, 0, "R10 reset pfStatus");

    // R1: threshold boundary sweep on both levels, delay 0
    for (int lv = 0; lv < 2; lv++) begin
      for (int c = 0; c < 8; c++) begin
        doReset();
        lvlCfg[lv]     = {4'd0, 1'b1, 3'(c)};   // bit 3 set, must be ignored
        lvlCfg[1 - lv] = {4'd15, 1'b0, 3'd7};
        curSample = limitOf(c) + 16'sd1;
        cyc(3);
        chk(faultFlag, 0, "R1 just above limit");
        curSample = limitOf(c);
        cyc(1);
        chk(faultFlag, 1, "R1 at limit trips");
        chk(dsgOff, 1, "R2 dsgOff on trip");
      end
    end

    // R2: qualification delay sweep
    for (int d = 0; d < 16; d++) begin
      doReset();
      lvlCfg[0] = {4'(d), 1'b0, 3'd0};
      lvlCfg[1] = {4'd15, 1'b0, 3'd7};
      curSample = -16'sd100;
      cyc(1);
      chk(faultFlag, d == 0, "R2 delay k=0");
      for (int k = 1; k <= 16; k++) begin
        tickOnce();
        chk(faultFlag, k >= d, "R2 delay ticks");
      end
    end

    // R3: recovery time sweep
    lvlCfg[0] = 8'h00;
    lvlCfg[1] = {4'd15, 1'b0, 3'd7};
    for (int r = 0; r < 6; r++) begin
      int eff;
      eff = (r == 0) ? 1 : r;
      doReset();
      recTime = 8'(r);
      tripOnce();
      for (int k = 1; k <= eff; k++) begin
        tickOnce();
        chk(faultFlag, k < eff, "R3 recovery fault");
        chk(dsgOff, k < eff, "R3 recovery dsgOff");
      end
    end

    // R5/R6: decrement period sweep with pf alert gating
    for (int p = 0; p < 5; p++) begin
      int eff;
      eff = (p == 0) ? 1 : p;
      doReset();
      recTime = 8'd1;
      decPeriod = 8'(p);
      pfEnable = p[0];
      tripOnce();
      chk(alertFlag, 1, "R6 alert after trip");
      for (int k = 1; k <= eff; k++) begin
        tickOnce();
        chk(alertFlag, k < eff, "R5 decrement alert");
        chk(pfAlert, (k < eff) && p[0], "R6 pfAlert gating");
      end
    end
    pfEnable = 1'b0;

    // R4: held trip counts once; counter saturation at 15
    doReset();
    recTime = 8'd255;
    decPeriod = 8'd255;
    latchLimit = 4'd2;
    curSample = -16'sd100;
    cyc(10);
    chk(latchFlag, 0, "R4 held trip single count");
    doReset();
    latchLimit = 4'd0;
    recTime = 8'd1;
    for (int i = 0; i < 20; i++) begin
      tripOnce();
      tickOnce();
    end
    decPeriod = 8'd1;
    for (int k = 1; k <= 15; k++) begin
      tickOnce();
      if (k >= 14) chk(alertFlag, k < 15, "R4 saturated count drains in 15");
    end

    // R7/R9/R10: latch escalation, trip blocking, timed release
    for (int lim = 1; lim <= 4; lim++) begin
      for (int e = 0; e < 2; e++) begin
        resetMode = 1'b1;
        doReset();
        recTime = 8'd1;
        decPeriod = 8'd255;
        latchLimit = 4'(lim);
        rstTime = 8'(lim + 1);
        pfEnable = e[0];
        for (int i = 1; i <= lim; i++) begin
          tripOnce();
          cyc(1);
          if (i < lim) begin
            chk(latchFlag, 0, "R7 below limit no latch");
            chk(pfAlert, e[0], "R6 pfAlert before latch");
            tickOnce();
          end else begin
            chk(latchFlag, 1, "R7 latch set");
            chk(faultFlag, 0, "R7 fault cleared");
            chk(alertFlag, 0, "R7 alert cleared");
            chk(pfAlert, 0, "R7 pfAlert cleared");
            chk(pfStatus, e[0], "R7 pfStatus");
            chk(dsgOff, 1, "R7 dsgOff latched");
          end
        end
        curSample = -16'sd100;
        cyc(3);
        chk(faultFlag, 0, "R7 trips ignored while latched");
        curSample = '0;
        for (int k = 1; k <= lim + 1; k++) begin
          tickOnce();
          chk(latchFlag, k < lim + 1, "R9 timed release");
        end
        chk(dsgOff, 0, "R9 dsgOff after release");
        chk(pfStatus, e[0], "R10 pfStatus sticky");
        doReset();
        chk(pfStatus, 0, "R10 reset clears pfStatus");
      end
    end
    pfEnable = 1'b0;

    // R8: presence sequence release
    resetMode = 1'b0;
    doReset();
    latchLimit = 4'd1;
    recTime = 8'd1;
    presPin = 1'b0;
    tripOnce();
    cyc(2);
    for (int k = 0; k < 6; k++) tickOnce();
    chk(latchFlag, 1, "R8 ticks do not release");
    presPin = 1'b1;
    cyc(4);
    chk(latchFlag, 1, "R8 high alone keeps latch");
    presPin = 1'b0;
    cyc(4);
    chk(latchFlag, 0, "R8 low-high-low releases");
    chk(dsgOff, 0, "R8 dsgOff after release");

    doReset();
    presPin = 1'b1;
    cyc(3);
    tripOnce();
    cyc(4);
    chk(latchFlag, 1, "R8 latched with pin high");
    presPin = 1'b0;
    cyc(4);
    chk(latchFlag, 1, "R8 high-low only keeps latch");
    presPin = 1'b1;
    cyc(4);
    chk(latchFlag, 1, "R8 second high keeps latch");
    presPin = 1'b0;
    cyc(4);
    chk(latchFlag, 0, "R8 full sequence releases");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule